// File: doc/BRIEF.md
# Watchdog Timer with Pre-warning

The block is a supervision counter for a processor subsystem. A 16-bit counter moves upward by one on each tick of a prescaled clock and must be reloaded by software, through a service strobe, before it wraps past its maximum value. Software chooses the count clock with a select bit: the system clock divided by 256 or by 16384. In normal operation each service loads the counter with a value that software supplies. The gap between that value and the wrap point sets the service deadline.

A missed deadline does not reset the system at once. A wrap, or a pulse on the error input from the access checker, sends the block into a warning phase. In this phase it raises a non-maskable interrupt and loads the fixed value 0xFF00. It then counts 256 further ticks, and nothing can stop this count. Only when that count also wraps does the block request a system reset.

After system reset the counter starts in a time-out phase, counting from the same fixed value, until the first service. A power-on-only flag remembers that a watchdog reset has happened. A second watchdog reset latches a lockout that keeps the reset request asserted until power-on reset.

Top module: `wdt_prewarn`

## Requirements
- R1: After power-on reset, nmi_o, reset_req_o and held_o are 0. After any reset, the block is in time-out phase, with the counter at 0xFF00 and the prescaler at zero.
- R2: The counter advances once every DIV_LO clocks when presc_sel_i is 0, and once every DIV_HI clocks when it is 1. A service, or an entry into the warning phase, restarts the prescaler.
- R3: A service_i pulse in time-out or normal phase loads reload_i and selects normal phase. The next wrap then comes after 0x10000 minus reload_i ticks.
- R4: A wrap from 0xFFFF in time-out or normal phase enters the warning phase. The warning phase sets nmi_o to 1 on the following cycle and reloads 0xFF00.
- R5: error_i in time-out or normal phase enters the warning phase exactly as a wrap does. error_i wins over a service_i in the same cycle.
- R6: In the warning phase, service_i, error_i and disable_i have no effect. After 256 ticks the wrap drops nmi_o and sets reset_req_o on the following cycle.
- R7: disable_i set in normal phase freezes the counter. In time-out and warning phases, disable_i has no effect.
- R8: reset_req_o stays 1 until rst_ni is asserted. The first watchdog reset after power-on leaves held_o at 0.
- R9: A second watchdog reset without power-on reset in between sets held_o. held_o keeps reset_req_o at 1 through rst_ni until por_ni is asserted.
- R10: A service_i pulse in the same cycle as a wrap tick counts as timely: the block stays in normal phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset |
| service_i | input | 1 | Service strobe, one cycle |
| reload_i | input | 16 | User reload value for normal phase |
| presc_sel_i | input | 1 | 0: divide by DIV_LO, 1: divide by DIV_HI |
| disable_i | input | 1 | Freeze counting in normal phase |
| error_i | input | 1 | Access error from the access checker |
| nmi_o | output | 1 | Non-maskable interrupt, high during warning phase |
| reset_req_o | output | 1 | System reset request |
| held_o | output | 1 | Double-reset lockout flag |

## Verification
A behavioural model in the bench runs alongside the design and is compared with it on every cycle. Services at spaced intervals under both prescaler selects show whether the tick rate and the user reload set the deadline. A service placed on the exact wrap tick, and an error paired with a service, show which event has priority. Disable held in normal phase is compared with disable held in time-out phase, and strobes sent during the warning phase show that it cannot be stopped. Two watchdog resets separated only by a system reset, and a single one after power-on, show the difference between the remembered flag and the lockout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_TIMEOUT = 2'd0,
    WD_NORMAL  = 2'd1,
    WD_WARN    = 2'd2,
    WD_TRIPPED = 2'd3
  } wd_mode_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_LO = 256,
  parameter int unsigned DIV_HI = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = $clog2(DIV_HI);
  localparam logic [PRE_W-1:0] LIM_LO = PRE_W'(DIV_LO - 1);
  localparam logic [PRE_W-1:0] LIM_HI = PRE_W'(DIV_HI - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim    = sel_i ? LIM_HI : LIM_LO;
  assign tick_o = (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clear_i || tick_o) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PW_TICKS = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             service_i,
  input  logic             error_i,
  input  logic             disable_i,
  input  logic [CNT_W-1:0] reload_i,
  output wd_mode_e         mode_o,
  output logic             clear_o,
  output logic             trip_o
);
  localparam logic [CNT_W-1:0] FIXED  = CNT_W'((1 << CNT_W) - PW_TICKS);
  localparam logic [CNT_W-1:0] CNTMAX = '1;

  wd_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_phase;
  logic             wrap;

  assign open_phase = (mode_q == WD_TIMEOUT) || (mode_q == WD_NORMAL);
  assign wrap       = tick_i && (cnt_q == CNTMAX);
  assign clear_o    = open_phase && (error_i || service_i);
  assign mode_o     = mode_q;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    trip_o = 1'b0;
    unique case (mode_q)
      WD_TIMEOUT, WD_NORMAL: begin
        if (error_i) begin
          mode_d = WD_WARN;
          cnt_d  = FIXED;
        end else if (service_i) begin
          mode_d = WD_NORMAL;
          cnt_d  = reload_i;
        end else if (tick_i && !(mode_q == WD_NORMAL && disable_i)) begin
          if (wrap) begin
            mode_d = WD_WARN;
            cnt_d  = FIXED;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      WD_WARN: begin
        if (wrap) begin
          mode_d = WD_TRIPPED;
          trip_o = 1'b1;
        end else if (tick_i) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= WD_TIMEOUT;
      cnt_q  <= FIXED;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5
  error_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_phase && error_i) |=> (mode_q == WD_WARN && cnt_q == FIXED));
  // R3
  service_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_phase && service_i && !error_i) |=>
      (mode_q == WD_NORMAL && cnt_q == $past(reload_i)));
  // R7
  disable_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WD_NORMAL && disable_i && !service_i && !error_i) |=> $stable(cnt_q));
  // R6
  tripped_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == WD_TRIPPED) |=> (mode_q == WD_TRIPPED));
endmodule

// File: rtl/wdt_lockout.sv
module wdt_lockout (
  input  logic clk_i,
  input  logic por_ni,
  input  logic trip_i,
  output logic held_o
);
  logic flag_q, held_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      flag_q <= 1'b0;
      held_q <= 1'b0;
    end else if (trip_i) begin
      flag_q <= 1'b1;
      if (flag_q) held_q <= 1'b1;
    end
  end

  assign held_o = held_q;

  // R9
  held_sticky_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    held_q |=> held_q);
  // R8
  held_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    $rose(held_q) |-> $past(flag_q));
endmodule

// File: rtl/wdt_prewarn.sv
module wdt_prewarn
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned PW_TICKS = 256,
  parameter int unsigned DIV_LO   = 256,
  parameter int unsigned DIV_HI   = 16384
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             service_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             presc_sel_i,
  input  logic             disable_i,
  input  logic             error_i,
  output logic             nmi_o,
  output logic             reset_req_o,
  output logic             held_o
);
  wd_mode_e mode;
  logic     tick, clear, trip, sys_rst_n, held;

  // power-on reset also resets the system domain
  assign sys_rst_n = rst_ni && por_ni;

  wdt_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (sys_rst_n),
    .sel_i  (presc_sel_i),
    .clear_i(clear),
    .tick_o (tick)
  );

  wdt_core #(.CNT_W(CNT_W), .PW_TICKS(PW_TICKS)) i_core (
    .clk_i    (clk_i),
    .rst_ni   (sys_rst_n),
    .tick_i   (tick),
    .service_i(service_i),
    .error_i  (error_i),
    .disable_i(disable_i),
    .reload_i (reload_i),
    .mode_o   (mode),
    .clear_o  (clear),
    .trip_o   (trip)
  );

  wdt_lockout i_lock (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .trip_i(trip),
    .held_o(held)
  );

  assign nmi_o       = (mode == WD_WARN);
  assign reset_req_o = (mode == WD_TRIPPED) || held;
  assign held_o      = held;

  // R6
  nmi_to_req_chk: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    trip |=> (reset_req_o && !nmi_o));
  // R9
  held_forces_req_chk: assert property (@(posedge clk_i) disable iff (!por_ni)
    held_o |-> reset_req_o);
endmodule

// File: tb/test_wdt_prewarn.sv
module test_wdt_prewarn;
  localparam int DL = 4;
  localparam int DH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic service = 1'b0, sel = 1'b0, dis = 1'b0, err = 1'b0;
  logic [15:0] reload = 16'h0;
  logic nmi, req, held;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  // model state: mode 0 timeout, 1 normal, 2 warn, 3 tripped
  int m_pre, m_cnt, m_mode, m_flag, m_held;

  always #10 clk = ~clk;

  wdt_prewarn #(.DIV_LO(DL), .DIV_HI(DH)) i_wdt_prewarn (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .service_i(service),
    .reload_i(reload), .presc_sel_i(sel), .disable_i(dis), .error_i(err),
    .nmi_o(nmi), .reset_req_o(req), .held_o(held)
  );

  always @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!por_n || !rst_n) begin
      if (!por_n) begin m_flag = 0; m_held = 0; end
      m_pre = 0; m_cnt = 16'hFF00; m_mode = 0;
    end else begin
      bit tk;
      tk = (m_pre >= (sel ? DH : DL) - 1);
      m_pre = tk ? 0 : m_pre + 1;
      if (m_mode <= 1) begin
        if (err) begin m_mode = 2; m_cnt = 16'hFF00; m_pre = 0; end
        else if (service) begin m_mode = 1; m_cnt = reload; m_pre = 0; end
        else if (tk && !(m_mode == 1 && dis)) begin
          if (m_cnt == 16'hFFFF) begin m_mode = 2; m_cnt = 16'hFF00; end
          else m_cnt++;
        end
      end else if (m_mode == 2 && tk) begin
        if (m_cnt == 16'hFFFF) begin
          m_mode = 3;
          if (m_flag != 0) m_held = 1;
          m_flag = 1;
        end else m_cnt++;
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog %s: actual=hung expected=done", tag);
      finish_run();
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      logic e_nmi, e_req, e_held;
      @(negedge clk);
      e_nmi  = (m_mode == 2);
      e_req  = (m_mode == 3) || (m_held != 0);
      e_held = (m_held != 0);
      checks++;
      if ({nmi, req, held} !== {e_nmi, e_req, e_held}) begin
        errors++;
        $display("FAIL %s: actual nmi,req,held=%b%b%b expected=%b%b%b",
                 tag, nmi, req, held, e_nmi, e_req, e_held);
      end
    end
  endtask

  task automatic serve(input logic [15:0] v);
    reload = v; service = 1'b1; cyc(1); service = 1'b0;
  endtask

  task automatic sys_reset();
    rst_n = 1'b0; cyc(3); rst_n = 1'b1;
  endtask

  initial begin
    cyc(3);
    por_n = 1'b1; rst_n = 1'b1;
    tag = "R1"; cyc(20);
    tag = "R3"; serve(16'hFFF0); cyc(40); serve(16'hFFF0); cyc(50);
    tag = "R2"; sel = 1'b1; serve(16'hFFF0); cyc(100); serve(16'hFFF0);
    cyc(1); sel = 1'b0; serve(16'hFFF0);
    tag = "R10";
    for (int k = 0; k < 3; k++) begin
      for (int w = 0; w < 200; w++) begin
        if (m_mode == 1 && m_cnt == 16'hFFFF && m_pre == DL - 1) break;
        cyc(1);
      end
      serve(16'hFFF0);
    end
    cyc(5);
    tag = "R7"; dis = 1'b1; cyc(300); dis = 1'b0;
    tag = "R4"; cyc(80);
    tag = "R6";
    service = 1'b1; cyc(2); service = 1'b0;
    err = 1'b1; cyc(2); err = 1'b0;
    dis = 1'b1; cyc(100); dis = 1'b0;
    cyc(1000);
    tag = "R8"; cyc(10); sys_reset(); cyc(5);
    tag = "R7"; dis = 1'b1; cyc(1040); dis = 1'b0;
    tag = "R9"; cyc(1100); sys_reset(); cyc(20);
    tag = "R1"; por_n = 1'b0; cyc(2); por_n = 1'b1; cyc(5);
    tag = "R5"; serve(16'hFFF0); cyc(10);
    err = 1'b1; service = 1'b1; cyc(1); err = 1'b0; service = 1'b0;
    cyc(1100);
    tag = "R8"; sys_reset(); cyc(5);
    tag = "R5"; err = 1'b1; cyc(1); err = 1'b0; cyc(20);
    finish_run();
  end
endmodule